// File: doc/BRIEF.md
# Packet-Granular Word-to-Bit Dual-Clock FIFO

This block carries data from a 32-bit write port in one clock domain to a 1-bit serial read port in a second, unrelated clock domain. Words are stored in one dual-port RAM that has a separate write clock and read clock. The RAM is written behaviourally so that block RAM can be inferred. The read side takes each stored word and shifts it out bit by bit.

Occupancy is counted in whole packets of 16 words, which is 512 serial bits. The buffer holds 4 packets. The writer commits a packet when its 16th word is stored. The reader releases a packet slot only when the last of its 512 bits has been shifted out. Only these packet counts cross between the clock domains, as small Gray-coded values through two-flop synchronisers. Because a count changes at most once per 16 write cycles or 512 read cycles, the write and read word pointers can stay plain binary counters.

Each side has its own synchronous active-high reset, and both resets are applied together at start-up. The writer stops when `w_full` is high. The reader pulses or holds `r_en` whenever `r_empty` is low.

Top module: `pkt_serial_fifo`

## Requirements
- R1: After both resets, `w_full` is 0, `r_empty` is 1 and `r_bit` is 0.
- R2: A word presented on `w_data` with `w_en` high and `w_full` low is stored. Stored words come out in the order they were written.
- R3: A write attempted while `w_full` is high is dropped. It changes neither the stored data nor the write position.
- R4: Each word leaves the read port most significant bit first (bit 31 first). On every `r_clk` edge where `r_en` is high and `r_empty` is low, `r_bit` takes the next bit.
- R5: While complete packets are available, consecutive enabled read cycles give an unbroken bit stream across word and packet boundaries.
- R6: `r_empty` stays high until a packet of 16 words is completely written. A packet holding 15 or fewer words does not clear it. `r_empty` goes high again once every committed packet has been fully shifted out.
- R7: An `r_en` pulse while `r_empty` is high is ignored, and `r_bit` keeps its last value.
- R8: `w_full` is high exactly while 4 committed packets are unreleased. Reading fewer than 512 bits of a packet does not release its slot.
- R9: After the 512th bit of a packet is shifted out, the slot count crosses to the write domain as a Gray code that changes one bit per step. `w_full` then falls within a few `w_clk` cycles.
- R10: Data order and the flags stay correct after the word pointers and packet counters wrap around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w_clk | input | 1 | Write-domain clock |
| w_rst | input | 1 | Synchronous active-high reset, write domain |
| w_en | input | 1 | Write request for `w_data` |
| w_data | input | 32 | Word to store |
| w_full | output | 1 | Four committed packets await release |
| r_clk | input | 1 | Read-domain clock |
| r_rst | input | 1 | Synchronous active-high reset, read domain |
| r_en | input | 1 | Shift one bit out |
| r_bit | output | 1 | Serial data, registered |
| r_empty | output | 1 | No complete packet staged for reading |

## Verification
- **Partial packet.** The bench stops after 15 words of a packet. A design that counted words instead of packets would clear `r_empty` too early.
- **Partial read.** With the buffer full, the bench reads 511 bits and checks that `w_full` holds. A reader that released at a word boundary, or one bit early, would drop `w_full` at that point.
- **Write at full.** The bench writes a distinctive word while `w_full` is high. If the guard were missing, that word would overwrite the first word of the oldest packet, and it would appear in the checked bit stream.
- **Boundaries and wrap.** Long continuous reads span word and packet boundaries, and repeated rounds wrap the counters. A missing prefetch, or a slot or offset decode error, would show up as a shifted or corrupted bit sequence.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int unsigned PF_DATA_W    = 32;
  localparam int unsigned PF_PKT_WORDS = 16;
  localparam int unsigned PF_PKT_SLOTS = 4;

  typedef enum logic {RD_IDLE, RD_STREAM} rd_state_e;
endpackage

// File: rtl/pf_dpram.sv
module pf_dpram #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 6
) (
  input  logic          w_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          r_clk,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge w_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // registered read port: one cycle of latency, block RAM friendly
  always_ff @(posedge r_clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pf_gray_sync.sv
module pf_gray_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  always_comb begin
    bin_out[W-1] = s2[W-1];
    for (int i = int'(W) - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ s2[i];
  end

  // R9: the synchronised count moves by a single Gray step at a time
  p_gray_one_step_r9: assert property (@(posedge clk) disable iff (rst)
    $countones(s2 ^ $past(s2)) <= 1);
endmodule

// File: rtl/pf_wr_side.sv
module pf_wr_side #(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 6,
  parameter int unsigned WOFF_W = 4,
  parameter int unsigned CW     = 3,
  parameter int unsigned SLOTS  = 4
) (
  input  logic          w_clk,
  input  logic          w_rst,
  input  logic          w_en,
  input  logic [DW-1:0] w_data,
  input  logic [CW-1:0] rd_cnt_bin,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] wr_gray,
  output logic          w_full
);
  localparam logic [CW-1:0] SLOTS_C = CW'(SLOTS);

  logic [AW-1:0] waddr;
  logic [CW-1:0] wr_cnt, wr_cnt_nx, occ;
  logic          accept, pkt_done;

  assign occ       = wr_cnt - rd_cnt_bin;
  assign w_full    = (occ == SLOTS_C);
  assign accept    = w_en && !w_full;
  assign pkt_done  = accept && (waddr[WOFF_W-1:0] == '1);
  assign wr_cnt_nx = wr_cnt + 1'b1;

  always_ff @(posedge w_clk) begin
    if (w_rst) begin
      waddr   <= '0;
      wr_cnt  <= '0;
      wr_gray <= '0;
    end else begin
      if (accept) waddr <= waddr + 1'b1;
      if (pkt_done) begin
        wr_cnt  <= wr_cnt_nx;
        wr_gray <= wr_cnt_nx ^ (wr_cnt_nx >> 1);
      end
    end
  end

  assign mem_we    = accept;
  assign mem_waddr = waddr;
  assign mem_wdata = w_data;

  // R8: committed-but-unreleased packets never exceed the slot count
  p_occ_bound_r8: assert property (@(posedge w_clk) disable iff (w_rst)
    occ <= SLOTS_C);
  // R3: a write offered while full leaves the write position untouched
  p_no_write_when_full_r3: assert property (@(posedge w_clk) disable iff (w_rst)
    (w_en && w_full) |=> $stable(waddr));
endmodule

// File: rtl/pf_rd_side.sv
module pf_rd_side
  import pf_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 6,
  parameter int unsigned WOFF_W = 4,
  parameter int unsigned CW     = 3,
  parameter int unsigned BIT_W  = 5
) (
  input  logic          r_clk,
  input  logic          r_rst,
  input  logic          r_en,
  input  logic [CW-1:0] wr_cnt_bin,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic [CW-1:0] rd_gray,
  output logic          r_bit,
  output logic          r_empty
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DW - 1);

  rd_state_e       state;
  logic [DW-1:0]   cur;
  logic [BIT_W-1:0] bcnt;
  logic [WOFF_W-1:0] cur_ofs;
  logic [AW-1:0]   raddr;
  logic [CW-1:0]   rd_cnt, rd_cnt_nx, avail;
  logic            shift, word_end, pkt_end;

  assign avail     = wr_cnt_bin - rd_cnt;
  assign rd_cnt_nx = rd_cnt + 1'b1;
  assign shift     = r_en && (state == RD_STREAM);
  assign word_end  = shift && (bcnt == LAST_BIT);
  assign pkt_end   = word_end && (cur_ofs == '1);

  always_ff @(posedge r_clk) begin
    if (r_rst) begin
      state   <= RD_IDLE;
      cur     <= '0;
      bcnt    <= '0;
      cur_ofs <= '0;
      raddr   <= '0;
      rd_cnt  <= '0;
      rd_gray <= '0;
      r_bit   <= 1'b0;
    end else begin
      case (state)
        RD_IDLE: begin
          // raddr already holds the first word of the next packet;
          // mem_rdata was captured from it on the previous edge
          if (avail != '0) begin
            cur     <= mem_rdata;
            raddr   <= raddr + 1'b1;
            cur_ofs <= '0;
            bcnt    <= '0;
            state   <= RD_STREAM;
          end
        end
        RD_STREAM: begin
          if (shift) begin
            r_bit <= cur[DW-1];
            cur   <= cur << 1;
            bcnt  <= bcnt + 1'b1;
            if (word_end) begin
              bcnt <= '0;
              if (pkt_end) begin
                rd_cnt  <= rd_cnt_nx;
                rd_gray <= rd_cnt_nx ^ (rd_cnt_nx >> 1);
              end
              if (pkt_end && (avail < CW'(2))) begin
                state <= RD_IDLE;
              end else begin
                // prefetched word loads with no gap in the stream
                cur     <= mem_rdata;
                raddr   <= raddr + 1'b1;
                cur_ofs <= cur_ofs + 1'b1;
              end
            end
          end
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign mem_raddr = raddr;
  assign r_empty   = (state == RD_IDLE);

  // R7: a read request while empty leaves the serial output unchanged
  p_empty_holds_bit_r7: assert property (@(posedge r_clk) disable iff (r_rst)
    (r_en && r_empty) |=> $stable(r_bit));
  // R8: a slot is released only on the final bit of a packet
  p_release_at_packet_end_r8: assert property (@(posedge r_clk) disable iff (r_rst)
    !pkt_end |=> $stable(rd_cnt));
  // R6: streaming only ever draws on a committed packet
  p_stream_committed_r6: assert property (@(posedge r_clk) disable iff (r_rst)
    (state == RD_STREAM) |-> (avail != '0));
endmodule

// File: rtl/pkt_serial_fifo.sv
module pkt_serial_fifo
  import pf_pkg::*;
#(
  parameter int unsigned DATA_W    = PF_DATA_W,
  parameter int unsigned PKT_WORDS = PF_PKT_WORDS,
  parameter int unsigned PKT_SLOTS = PF_PKT_SLOTS
) (
  input  logic              w_clk,
  input  logic              w_rst,
  input  logic              w_en,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_full,
  input  logic              r_clk,
  input  logic              r_rst,
  input  logic              r_en,
  output logic              r_bit,
  output logic              r_empty
);
  localparam int unsigned WOFF_W = $clog2(PKT_WORDS);
  localparam int unsigned SLOT_W = $clog2(PKT_SLOTS);
  localparam int unsigned AW     = WOFF_W + SLOT_W;
  localparam int unsigned CW     = SLOT_W + 1;
  localparam int unsigned BIT_W  = $clog2(DATA_W);

  logic              mem_we;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [CW-1:0]     wr_gray, rd_gray, wr_cnt_in_r, rd_cnt_in_w;

  pf_wr_side #(
    .DW(DATA_W), .AW(AW), .WOFF_W(WOFF_W), .CW(CW), .SLOTS(PKT_SLOTS)
  ) u_wr (
    .w_clk(w_clk), .w_rst(w_rst), .w_en(w_en), .w_data(w_data),
    .rd_cnt_bin(rd_cnt_in_w), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .wr_gray(wr_gray), .w_full(w_full)
  );

  pf_dpram #(.DW(DATA_W), .AW(AW)) u_ram (
    .w_clk(w_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .r_clk(r_clk), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  pf_gray_sync #(.W(CW)) u_w2r (
    .clk(r_clk), .rst(r_rst), .gray_in(wr_gray), .bin_out(wr_cnt_in_r)
  );

  pf_gray_sync #(.W(CW)) u_r2w (
    .clk(w_clk), .rst(w_rst), .gray_in(rd_gray), .bin_out(rd_cnt_in_w)
  );

  pf_rd_side #(
    .DW(DATA_W), .AW(AW), .WOFF_W(WOFF_W), .CW(CW), .BIT_W(BIT_W)
  ) u_rd (
    .r_clk(r_clk), .r_rst(r_rst), .r_en(r_en), .wr_cnt_bin(wr_cnt_in_r),
    .mem_rdata(mem_rdata), .mem_raddr(mem_raddr), .rd_gray(rd_gray),
    .r_bit(r_bit), .r_empty(r_empty)
  );
endmodule

// File: tb/tb_pkt_serial_fifo.sv
module tb_pkt_serial_fifo;
  logic        w_clk = 1'b0, r_clk = 1'b0;
  logic        w_rst = 1'b1, r_rst = 1'b1;
  logic        w_en = 1'b0, r_en = 1'b0;
  logic [31:0] w_data = '0;
  logic        w_full, r_bit, r_empty;

  int checks = 0, fails = 0;
  int wk = 0, rk = 0, rb = 0;
  logic done = 1'b0;
  logic last_b;

  always #5 w_clk = ~w_clk;
  always #7 r_clk = ~r_clk;

  pkt_serial_fifo dut (
    .w_clk(w_clk), .w_rst(w_rst), .w_en(w_en), .w_data(w_data), .w_full(w_full),
    .r_clk(r_clk), .r_rst(r_rst), .r_en(r_en), .r_bit(r_bit), .r_empty(r_empty)
  );

  function automatic logic [31:0] word_val(input int k);
    return (32'(k) * 32'h9E37_79B1) ^ 32'hC3A5_5A3C ^ (32'(k) << 24);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_words(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge w_clk);
      w_en   = 1'b1;
      w_data = word_val(wk);
      wk++;
    end
    @(negedge w_clk);
    w_en = 1'b0;
  endtask

  task automatic wait_ready();
    while (r_empty) @(negedge r_clk);
  endtask

  task automatic read_bits(input int n, input string req);
    @(negedge r_clk);
    r_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge r_clk);
      chk({31'd0, r_bit}, {31'd0, word_val(rk)[31-rb]}, req);
      rb++;
      if (rb == 32) begin
        rb = 0;
        rk++;
      end
    end
    r_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge w_clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge w_clk);
    w_rst = 1'b0;
    r_rst = 1'b0;
    repeat (3) @(negedge r_clk);
    chk({31'd0, w_full},  32'd0, "R1 w_full");
    chk({31'd0, r_empty}, 32'd1, "R1 r_empty");
    chk({31'd0, r_bit},   32'd0, "R1 r_bit");

    // R6: fifteen words must not clear empty
    write_words(15);
    repeat (12) @(negedge r_clk);
    chk({31'd0, r_empty}, 32'd1, "R6 partial packet");
    // R7: reads while empty are ignored
    r_en = 1'b1;
    repeat (5) @(negedge r_clk);
    r_en = 1'b0;
    chk({31'd0, r_bit}, 32'd0, "R7 read while empty");

    write_words(1);
    wait_ready();
    chk({31'd0, r_empty}, 32'd0, "R6 packet complete");

    // R8: full only on the fourth committed packet
    write_words(47);
    chk({31'd0, w_full}, 32'd0, "R8 63 words");
    write_words(1);
    chk({31'd0, w_full}, 32'd1, "R8 64 words");

    // R3: writes while full are dropped
    @(negedge w_clk);
    w_en   = 1'b1;
    w_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge w_clk);
    w_en = 1'b0;
    chk({31'd0, w_full}, 32'd1, "R3 still full");

    // R8: 511 bits do not release the slot
    read_bits(511, "R2 R3 R4 first packet");
    repeat (10) @(negedge w_clk);
    chk({31'd0, w_full}, 32'd1, "R8 partial read");
    // R9: the 512th bit releases it
    read_bits(1, "R4 last bit");
    repeat (8) @(negedge w_clk);
    chk({31'd0, w_full}, 32'd0, "R9 release");

    // R5: three packets in one unbroken stream
    read_bits(1536, "R5 continuous");
    repeat (6) @(negedge r_clk);
    chk({31'd0, r_empty}, 32'd1, "R6 drained");

    last_b = r_bit;
    r_en = 1'b1;
    repeat (5) @(negedge r_clk);
    r_en = 1'b0;
    chk({31'd0, r_bit}, {31'd0, last_b}, "R7 hold after drain");

    // R10: several rounds to wrap pointers and counters
    for (int r = 0; r < 5; r++) begin
      write_words(32);
      wait_ready();
      read_bits(1024, "R10 wrap");
      repeat (6) @(negedge r_clk);
      chk({31'd0, r_empty}, 32'd1, "R10 empty after round");
      chk({31'd0, w_full},  32'd0, "R10 not full after round");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule